// File: doc/BRIEF.md
# Dual-Port Microcode RAM Controller

This block is a small RAM that two masters share. The host reaches it over a simple request/response system bus. A coprocessor that runs microcode fetches words from the same array through a private read port. The host sees two address windows. The first is a fixed 64-byte window of control and status registers. The second is the array itself, which sits at a 4 KB-aligned location that the host chooses by writing a relocation register.

A configuration bit hands the array over to the coprocessor as its microcode store. While that bit is set, no register setting changes how the array behaves:
- host writes to the array are discarded,
- host reads of the array return zero,
- relocation writes are ignored,
- a signature scan can neither start nor advance.

Outside that mode, the host can start a built-in scan. The scan feeds the array contents, one word per clock, into a 32-bit multiple-input signature register. This gives a quick integrity check of the loaded microcode.

Top module: `ucode_ram_ctrl`

## Requirements
- R1: After reset, all array words, the relocation register, the signature, the remaining-word count and every configuration bit are zero, and `bus_ack`, `bus_berr`, `bus_rdata` and `cp_rdata` are low.
- R2: A register-window access with `bus_sup` low gets `bus_berr` high and `bus_ack` low in the cycle after the request, with read data zero, and it changes no register.
- R3: Every word offset in the 64-byte register window is acknowledged for a supervisor access. Offsets 0x18 through 0x3C have no register: they read as zero, and writes to them have no effect.
- R4: Register layout by offset:
  - 0x00 configuration: bit 15 is microcode mode (read/write); bit 2 is scan busy and bit 1 is scan done (both read-only); a write of 1 to bit 0 starts a scan, and bit 0 reads 0.
  - 0x04 relocation: bits 31:12 only.
  - 0x08 signature high half, in bits 15:0.
  - 0x0C signature low half, in bits 15:0.
  - 0x10 remaining-word count (read-only).
  - 0x14 test control: bit 0 is scan hold.

  Register accesses always move the whole 32-bit word, whatever the size code. Every other bit reads zero and is unaffected by writes.
- R5: Array accesses use little-endian byte lanes. Size code 0 is a byte, on lane `addr[1:0]`. Size code 1 is a half-word, on lanes 1:0 when `addr[1]` is 0 and lanes 3:2 when it is 1. Size codes 2 and 3 are a full word. Write data is taken from its lane position, and reads return the whole word.
- R6: The array answers at relocation base plus 4×index, for index 0 to ARR_WORDS−1, with any privilege. Addresses outside both windows get neither `bus_ack` nor `bus_berr`.
- R7: A write to the relocation register is ignored while microcode mode is set.
- R8: While microcode mode is set, a host array write is acknowledged and discarded, and a host array read is acknowledged and returns zero.
- R9: When `cp_en` is high, `cp_rdata` shows the array word at `cp_addr` in the next cycle, in either mode.
- R10: Starting a scan clears the signature, loads the count with ARR_WORDS, and sets busy. The scan then folds one word per clock, from index 0 upward, using sig' = (sig<<1) ^ (sig[31] ? 0x00400007 : 0) ^ word. After ARR_WORDS steps, busy clears, done sets and the count is zero.
- R11: Once done, the signature holds its value until the next start. The scan stalls, with signature and count held, while scan hold is set.
- R12: A start request is ignored while microcode mode is set, or when the same write also sets microcode mode.
- R13: Every bus response comes exactly one cycle after the request and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Host request strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sup | input | 1 | 1 = supervisor data space access |
| bus_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data in lane position |
| bus_ack | output | 1 | Access completed |
| bus_berr | output | 1 | Privilege error on the register window |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| cp_en | input | 1 | Coprocessor fetch strobe |
| cp_addr | input | log2(ARR_WORDS) | Coprocessor word index |
| cp_rdata | output | 32 | Fetched microcode word |

## Verification
A wrong signature register or scan pointer shows up only when the host reads the two signature halves after done. A wrong pointer surfaces as a mismatch against a signature computed by an independent model, ARR_WORDS+1 cycles after the start. A stale mode bit shows at once: the very next array read returns zero or live data when it should not, and a relocation read returns a changed value. A wrong count or a hold that does not stall the scan appears as a wrong count value read mid-scan, and a privilege slip shows as `bus_ack` where `bus_berr` belongs, one cycle after the request.

// File: rtl/ucr_pkg.sv
package ucr_pkg;
  localparam logic [31:0] MISR_TAPS = 32'h0040_0007;

  // one compaction step of the signature register
  function automatic logic [31:0] misr_step(input logic [31:0] s, input logic [31:0] d);
    logic [31:0] fb;
    fb = s[31] ? MISR_TAPS : 32'h0;
    return {s[30:0], 1'b0} ^ fb ^ d;
  endfunction

  // byte lane enables for a host access
  function automatic logic [3:0] lane_en(input logic [1:0] sz, input logic [1:0] a);
    case (sz)
      2'd0:    return 4'b0001 << a;
      2'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/ucr_decode.sv
module ucr_decode #(
  parameter logic [31:0] REG_BASE = 32'h0030_4000,
  parameter int ARR_WORDS = 64,
  localparam int IW = $clog2(ARR_WORDS)
) (
  input  logic [29:0]   addr_w,
  input  logic [19:0]   base_hi,
  output logic          reg_hit,
  output logic          arr_hit,
  output logic [3:0]    reg_idx,
  output logic [IW-1:0] arr_idx
);
  localparam logic [9:0] ARR_LIM = 10'(ARR_WORDS);

  logic in_arr;
  assign reg_hit = (addr_w[29:4] == REG_BASE[31:6]);
  assign in_arr  = (addr_w[29:10] == base_hi) && (addr_w[9:0] < ARR_LIM);
  assign arr_hit = in_arr && !reg_hit;   // register window wins an overlap
  assign reg_idx = addr_w[3:0];
  assign arr_idx = addr_w[IW-1:0];
endmodule

// File: rtl/ucr_array.sv
module ucr_array #(
  parameter int ARR_WORDS = 64,
  localparam int IW = $clog2(ARR_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    be,
  input  logic [IW-1:0] host_idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   host_rdata,
  input  logic [IW-1:0] scan_idx,
  output logic [31:0]   scan_data,
  input  logic          cp_en,
  input  logic [IW-1:0] cp_addr,
  output logic [31:0]   cp_rdata
);
  logic [31:0] mem [ARR_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < 4; k++)
        if (be[k]) mem[host_idx][8*k +: 8] <= wdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cp_rdata <= '0;
    else if (cp_en) cp_rdata <= mem[cp_addr];
  end

  assign host_rdata = mem[host_idx];
  assign scan_data  = mem[scan_idx];
endmodule

// File: rtl/ucr_sig_engine.sv
module ucr_sig_engine
  import ucr_pkg::*;
#(
  parameter int ARR_WORDS = 64,
  localparam int IW = $clog2(ARR_WORDS),
  localparam int CW = $clog2(ARR_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pause,
  input  logic [31:0]   data,
  output logic [IW-1:0] ptr,
  output logic [31:0]   sig,
  output logic [CW-1:0] cnt,
  output logic          busy,
  output logic          done
);
  logic step;
  assign step = busy && !pause && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig <= '0; cnt <= '0; ptr <= '0; busy <= 1'b0; done <= 1'b0;
    end else if (start) begin
      sig  <= '0;
      cnt  <= CW'(ARR_WORDS);
      ptr  <= '0;
      busy <= 1'b1;
      done <= 1'b0;
    end else if (step) begin
      sig <= misr_step(sig, data);
      ptr <= ptr + 1'b1;
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(sig)); // R11
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pause && !start) |=> ($stable(cnt) && $stable(sig))); // R11
  AST_DONE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == '0 && !busy)); // R10
endmodule

// File: rtl/ucr_regs.sv
module ucr_regs #(
  parameter int ARR_WORDS = 64,
  localparam int CW = $clog2(ARR_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [3:0]    idx,
  input  logic [31:0]   wdata,
  input  logic [31:0]   sig,
  input  logic [CW-1:0] cnt,
  input  logic          busy,
  input  logic          done,
  output logic [31:0]   rdata,
  output logic          ucode,
  output logic [19:0]   base_hi,
  output logic          hold,
  output logic          start
);
  localparam logic [31:0] CFG_MASK  = 32'h0000_8000;
  localparam logic [31:0] BASE_MASK = 32'hFFFF_F000;
  localparam logic [31:0] TEST_MASK = 32'h0000_0001;

  logic [31:0] cfg_q, base_q, test_q;

  assign ucode   = cfg_q[15];
  assign base_hi = base_q[31:12];
  assign hold    = test_q[0];
  assign start   = we && (idx == 4'd0) && wdata[0] && !ucode && !wdata[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; base_q <= '0; test_q <= '0;
    end else if (we) begin
      case (idx)
        4'd0: cfg_q <= wdata & CFG_MASK;
        4'd1: if (!ucode) base_q <= wdata & BASE_MASK;
        4'd5: test_q <= wdata & TEST_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      4'd0:    rdata = cfg_q | {29'b0, busy, done, 1'b0};
      4'd1:    rdata = base_q;
      4'd2:    rdata = {16'b0, sig[31:16]};
      4'd3:    rdata = {16'b0, sig[15:0]};
      4'd4:    rdata = 32'(cnt);
      4'd5:    rdata = test_q;
      default: rdata = '0;
    endcase
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ucode |=> $stable(base_q)); // R7
endmodule

// File: rtl/ucode_ram_ctrl.sv
module ucode_ram_ctrl
  import ucr_pkg::*;
#(
  parameter logic [31:0] REG_BASE = 32'h0030_4000,
  parameter int ARR_WORDS = 64,
  localparam int IW = $clog2(ARR_WORDS),
  localparam int CW = $clog2(ARR_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_wr,
  input  logic          bus_sup,
  input  logic [1:0]    bus_size,
  input  logic [31:0]   bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic          bus_ack,
  output logic          bus_berr,
  output logic [31:0]   bus_rdata,
  input  logic          cp_en,
  input  logic [IW-1:0] cp_addr,
  output logic [31:0]   cp_rdata
);
  logic          reg_hit, arr_hit, ucode, hold, start, busy, done;
  logic [3:0]    reg_idx;
  logic [IW-1:0] arr_idx, scan_ptr;
  logic [19:0]   base_hi;
  logic [31:0]   reg_rdata, arr_rdata, scan_data, sig, rd_val;
  logic [CW-1:0] cnt;
  logic          arr_we, reg_we, priv_fault, good_hit;

  ucr_decode #(.REG_BASE(REG_BASE), .ARR_WORDS(ARR_WORDS)) dec_i (
    .addr_w(bus_addr[31:2]), .base_hi(base_hi), .reg_hit(reg_hit),
    .arr_hit(arr_hit), .reg_idx(reg_idx), .arr_idx(arr_idx));

  // internal events named for the assertions
  assign priv_fault = bus_req && reg_hit && !bus_sup;
  assign good_hit   = bus_req && (arr_hit || (reg_hit && bus_sup));
  assign arr_we     = bus_req && bus_wr && arr_hit && !ucode;
  assign reg_we     = bus_req && bus_wr && reg_hit && bus_sup;

  ucr_array #(.ARR_WORDS(ARR_WORDS)) arr_i (
    .clk(clk), .rst_n(rst_n), .wr_en(arr_we), .be(lane_en(bus_size, bus_addr[1:0])),
    .host_idx(arr_idx), .wdata(bus_wdata), .host_rdata(arr_rdata),
    .scan_idx(scan_ptr), .scan_data(scan_data),
    .cp_en(cp_en), .cp_addr(cp_addr), .cp_rdata(cp_rdata));

  ucr_regs #(.ARR_WORDS(ARR_WORDS)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx), .wdata(bus_wdata),
    .sig(sig), .cnt(cnt), .busy(busy), .done(done), .rdata(reg_rdata),
    .ucode(ucode), .base_hi(base_hi), .hold(hold), .start(start));

  ucr_sig_engine #(.ARR_WORDS(ARR_WORDS)) sig_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pause(hold || ucode),
    .data(scan_data), .ptr(scan_ptr), .sig(sig), .cnt(cnt),
    .busy(busy), .done(done));

  always_comb begin
    if (reg_hit)      rd_val = bus_sup ? reg_rdata : '0;
    else if (arr_hit) rd_val = ucode ? '0 : arr_rdata;
    else              rd_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; bus_berr <= 1'b0; bus_rdata <= '0;
    end else begin
      bus_ack   <= good_hit;
      bus_berr  <= priv_fault;
      bus_rdata <= (bus_req && !bus_wr) ? rd_val : '0;
    end
  end

  AST_USER_BERR: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |=> (bus_berr && !bus_ack && bus_rdata == '0)); // R2
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack || bus_berr) |-> $past(bus_req)); // R13
  AST_NO_SCAN_IN_UCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ucode && !busy) |=> !busy); // R12
  AST_UCODE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && arr_hit && ucode) |=> (bus_ack && bus_rdata == '0)); // R8
endmodule

// File: tb/ucode_ram_ctrl_tb.sv
`timescale 1ns/1ps
module ucode_ram_ctrl_tb_top;
  localparam logic [31:0] RB = 32'h0030_4000;
  localparam int N = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_wr = 0, bus_sup = 0;
  logic [1:0] bus_size = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic bus_ack, bus_berr;
  logic [31:0] bus_rdata, cp_rdata;
  logic cp_en = 0;
  logic [5:0] cp_addr = 0;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] model [N];
  logic [31:0] exp_sig;

  always #2 clk = ~clk;

  ucode_ram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_sup(bus_sup),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_berr(bus_berr), .bus_rdata(bus_rdata),
    .cp_en(cp_en), .cp_addr(cp_addr), .cp_rdata(cp_rdata));

  typedef struct packed {
    logic wr; logic sup; logic [1:0] sz; logic [31:0] addr; logic [31:0] wd;
    logic ack; logic berr; logic [31:0] rd;
  } vec_t;

  localparam vec_t VECS [24] = '{
    '{1'b0, 1'b1, 2'd2, RB + 32'h00, 32'h0,         1'b1, 1'b0, 32'h0},         // R1 cfg
    '{1'b0, 1'b1, 2'd2, RB + 32'h04, 32'h0,         1'b1, 1'b0, 32'h0},         // R1 base
    '{1'b0, 1'b1, 2'd2, RB + 32'h0C, 32'h0,         1'b1, 1'b0, 32'h0},         // R1 sig
    '{1'b1, 1'b0, 2'd2, RB + 32'h04, 32'h0000_5000, 1'b0, 1'b1, 32'h0},         // R2 user wr
    '{1'b0, 1'b0, 2'd2, RB + 32'h00, 32'h0,         1'b0, 1'b1, 32'h0},         // R2 user rd
    '{1'b0, 1'b1, 2'd2, RB + 32'h04, 32'h0,         1'b1, 1'b0, 32'h0},         // R2 unchanged
    '{1'b0, 1'b1, 2'd2, RB + 32'h3C, 32'h0,         1'b1, 1'b0, 32'h0},         // R3 hole
    '{1'b1, 1'b1, 2'd2, RB + 32'h20, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0},         // R3 hole wr
    '{1'b1, 1'b1, 2'd2, RB + 32'h14, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0},         // R4 test wr
    '{1'b0, 1'b1, 2'd2, RB + 32'h14, 32'h0,         1'b1, 1'b0, 32'h0000_0001}, // R4 test rd
    '{1'b1, 1'b1, 2'd2, RB + 32'h14, 32'h0,         1'b1, 1'b0, 32'h0},         // R4 clear
    '{1'b1, 1'b0, 2'd2, 32'h0,       32'h1122_3344, 1'b1, 1'b0, 32'h0},         // R5 word
    '{1'b1, 1'b0, 2'd0, 32'h1,       32'h0000_AA00, 1'b1, 1'b0, 32'h0},         // R5 byte
    '{1'b0, 1'b0, 2'd2, 32'h0,       32'h0,         1'b1, 1'b0, 32'h1122_AA44}, // R5
    '{1'b1, 1'b1, 2'd1, 32'h6,       32'hBEEF_0000, 1'b1, 1'b0, 32'h0},         // R5 upper half
    '{1'b0, 1'b1, 2'd2, 32'h4,       32'h0,         1'b1, 1'b0, 32'hBEEF_0000}, // R5
    '{1'b1, 1'b1, 2'd1, 32'h4,       32'h0000_CAFE, 1'b1, 1'b0, 32'h0},         // R5 lower half
    '{1'b0, 1'b1, 2'd2, 32'h4,       32'h0,         1'b1, 1'b0, 32'hBEEF_CAFE}, // R5
    '{1'b0, 1'b1, 2'd2, 32'h0010_0000, 32'h0,       1'b0, 1'b0, 32'h0},         // R13 unmapped
    '{1'b1, 1'b1, 2'd2, RB + 32'h04, 32'h0000_1ABC, 1'b1, 1'b0, 32'h0},         // R6 relocate
    '{1'b0, 1'b1, 2'd2, RB + 32'h04, 32'h0,         1'b1, 1'b0, 32'h0000_1000}, // R4/R6
    '{1'b0, 1'b0, 2'd2, 32'h1000,    32'h0,         1'b1, 1'b0, 32'h1122_AA44}, // R6 new loc
    '{1'b0, 1'b0, 2'd2, 32'h0,       32'h0,         1'b0, 1'b0, 32'h0},         // R6 old loc
    '{1'b0, 1'b0, 2'd2, 32'h1100,    32'h0,         1'b0, 1'b0, 32'h0}          // R6 past end
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic sup, input logic [1:0] sz,
                     input logic [31:0] a, input logic [31:0] wd,
                     output logic ack, output logic berr, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1; bus_wr = wr; bus_sup = sup; bus_size = sz; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_req = 0;
    ack = bus_ack; berr = bus_berr; rd = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [31:0] a, input logic [31:0] exp);
    logic k, b; logic [31:0] d;
    bus(1'b0, 1'b1, 2'd2, a, 32'h0, k, b, d);
    chk(tag, {b, k, d[29:0]}, {2'b01, exp[29:0]});
    chk(tag, d, exp);
  endtask

  task automatic wr_do(input logic [31:0] a, input logic [31:0] wd);
    logic k, b; logic [31:0] d;
    bus(1'b1, 1'b1, 2'd2, a, wd, k, b, d);
    chk("R13 write ack", {31'b0, k}, 32'h1);
  endtask

  task automatic cp_chk(input string tag, input logic [5:0] i, input logic [31:0] exp);
    @(negedge clk); cp_en = 1; cp_addr = i;
    @(negedge clk); cp_en = 0;
    chk(tag, cp_rdata, exp);
  endtask

  // independent signature model: polynomial x^32+x^22+x^2+x+1
  function automatic logic [31:0] model_sig();
    logic [31:0] s = 32'h0;
    for (int i = 0; i < N; i++) begin
      logic msb = s[31];
      s = s << 1;
      if (msb) s = s ^ ((32'h1 << 22) | 32'h7);
      s = s ^ model[i];
    end
    return s;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic k, b; logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {bus_ack, bus_berr, 30'b0}, 32'h0);
    chk("R1 reset rdata", bus_rdata, 32'h0);
    rst_n = 1;
    cp_chk("R1 cp reset", 6'd5, 32'h0);

    for (int v = 0; v < 24; v++) begin
      bus(VECS[v].wr, VECS[v].sup, VECS[v].sz, VECS[v].addr, VECS[v].wd, k, b, d);
      chk($sformatf("vec%0d ack/berr R2 R3 R6 R13", v), {30'b0, k, b}, {30'b0, VECS[v].ack, VECS[v].berr});
      chk($sformatf("vec%0d rdata R1 R4 R5", v), d, VECS[v].rd);
    end

    cp_chk("R9 cp word0", 6'd0, 32'h1122_AA44);
    cp_chk("R9 cp word1", 6'd1, 32'hBEEF_CAFE);

    // R10 full scan
    for (int i = 0; i < N; i++) begin
      model[i] = (32'(i) * 32'h0103_0507) ^ 32'hA5A5_0F0F;
      wr_do(32'h1000 + 32'(4 * i), model[i]);
    end
    exp_sig = model_sig();
    wr_do(RB, 32'h1);
    rd_chk("R10 busy mid-scan", RB, 32'h4);
    repeat (N + 4) @(negedge clk);
    rd_chk("R10 done", RB, 32'h2);
    rd_chk("R10 count zero", RB + 32'h10, 32'h0);
    rd_chk("R10 sig high", RB + 32'h08, {16'h0, exp_sig[31:16]});
    rd_chk("R10 sig low", RB + 32'h0C, {16'h0, exp_sig[15:0]});

    // R11 frozen after done, hold stalls
    wr_do(32'h1000, 32'hDEAD_BEEF);
    model[0] = 32'hDEAD_BEEF;
    rd_chk("R11 sig frozen", RB + 32'h0C, {16'h0, exp_sig[15:0]});
    wr_do(RB + 32'h14, 32'h1);
    wr_do(RB, 32'h1);
    repeat (10) @(negedge clk);
    rd_chk("R11 hold count", RB + 32'h10, 32'(N));
    rd_chk("R11 hold sig", RB + 32'h08, 32'h0);
    wr_do(RB + 32'h14, 32'h0);
    repeat (N + 4) @(negedge clk);
    exp_sig = model_sig();
    rd_chk("R11 resumed done", RB, 32'h2);
    rd_chk("R11 resumed sig", RB + 32'h0C, {16'h0, exp_sig[15:0]});

    // microcode mode
    wr_do(RB, 32'h8000);
    rd_chk("R4 mode bit", RB, 32'h8002);
    wr_do(RB + 32'h04, 32'h0000_2000);
    rd_chk("R7 base kept", RB + 32'h04, 32'h0000_1000);
    wr_do(32'h1000, 32'h1234_5678);
    bus(1'b0, 1'b0, 2'd2, 32'h1000, 32'h0, k, b, d);
    chk("R8 read ack", {31'b0, k}, 32'h1);
    chk("R8 read zero", d, 32'h0);
    wr_do(RB, 32'h8001);
    rd_chk("R12 no start count", RB + 32'h10, 32'h0);
    rd_chk("R12 no start cfg", RB, 32'h8002);
    cp_chk("R9 cp in mode, R8 discarded", 6'd0, 32'hDEAD_BEEF);
    wr_do(RB, 32'h0);
    rd_chk("R8 array unchanged", 32'h1000, 32'hDEAD_BEEF);
    rd_chk("R12 sig unchanged", RB + 32'h08, {16'h0, exp_sig[31:16]});

    finish_run();
  end
endmodule